// File: doc/BRIEF.md
# Oracle Local-Versus-Remote Placement Selector

This block makes the placement decision for one cache set of a core whose working set outgrows its private cache (a spiller). The decision is needed when that core misses in its private cache or hits in a peer's. The block is given the distance to the next use of each of the eight local ways and of the block in flight. These distances come from a future-access trace that is computed ahead of time. The block names the block whose next use lies farthest away. On a miss, that block goes to a peer cache whose core gives up capacity (a receiver). If the farthest block is the one just fetched, it goes straight to the receiver and never occupies a local way.

On a miss, the block also names the slot in a receiver cache that takes the displaced block. A free-running LFSR chooses a receiver, and the block first looks at the least recently used slot of that receiver. If that slot is empty or owned by a receiver core, it is used as is. If a spiller owns it, the block scans every receiver cache for that spiller's blocks and takes the one with the farthest next use. On a remote hit, the local set competes with the hit block. If the hit block is the farthest-used, it stays where it is. Otherwise it trades places with the farthest local block. Every operation ends with a supply strobe, because the requester receives its data whatever the placement.

Candidates are scanned one per cycle, so the compare logic stays one comparator deep. A done strobe marks the end of each decision.

Top module: `oracle_place_sel`

## Requirements
- R1: After reset, done_o, supply_o, victim_o, bypass_o, place_o, swap_o, rem_core_o and rem_way_o are all zero.
- R2: When a miss completes (op_i = 0), victim_o is the index of the candidate with the largest next-use distance. Candidates 0 to 7 are the local ways, and candidate 8 is the incoming block (cand_dist_i).
- R3: A block with no future use carries distance 8'hFF and counts as farthest. When distances are equal, the lowest candidate index wins, and the incoming block ranks as index 8.
- R4: When a miss completes, place_o is 1, and bypass_o is 1 exactly when victim_o is 8. When a remote hit completes, place_o and bypass_o are both 0.
- R5: On a miss, rem_core_o names a core whose role_i bit is 0 (0 = receiver, 1 = spiller). When only one core is a receiver, that core is named.
- R6: The receiver's candidate slot is entry rem_core*8 + way, where way is that core's 3-bit field in rem_lru_i. If that entry is invalid, or its owner core (2-bit field of rem_owner_i) is a receiver, then rem_way_o equals that way.
- R7: If the candidate slot is owned by a spiller S, then rem_core_o and rem_way_o name an entry with these properties: it is valid, it sits in a receiver core, it is owned by S, and it has the largest distance among such entries. Ties go to the lowest entry index core*8+way.
- R8: When a remote hit completes (op_i = 1), swap_o is 1 and victim_o is the farthest local way when a local way wins. When the hit block (index 8) wins, swap_o is 0 and victim_o is 8, and ties follow R3.
- R9: supply_o pulses together with done_o once for every completed operation, whichever placement is chosen.
- R10: For a remote hit, done_o rises at the 11th rising edge, counting from and including the edge that samples start_i.
- R11: A start_i pulse that arrives while an operation is in progress is ignored. Only one done_o follows, and its results belong to the first operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an operation (sampled while idle) |
| op_i | input | 1 | 0 = spiller miss, 1 = spiller remote hit |
| local_dist_i | input | 64 | Next-use distances of local ways 0..7, 8 bits each, way 0 in bits 7:0 |
| cand_dist_i | input | 8 | Next-use distance of the incoming or remotely hit block |
| role_i | input | 4 | Per-core role, 1 = spiller, 0 = receiver |
| rem_dist_i | input | 256 | Next-use distance of each receiver-set entry, entry core*8+way |
| rem_owner_i | input | 64 | Owning core of each entry, 2 bits each |
| rem_valid_i | input | 32 | Valid bit of each entry |
| rem_lru_i | input | 12 | LRU way of each core's set, 3 bits each |
| done_o | output | 1 | One-cycle strobe at the end of an operation |
| supply_o | output | 1 | Data-return strobe to the requester |
| victim_o | output | 4 | Chosen farthest-use candidate, 8 = incoming/hit block |
| bypass_o | output | 1 | Incoming block goes straight to a receiver |
| place_o | output | 1 | rem_core_o / rem_way_o hold a remote placement slot |
| rem_core_o | output | 2 | Receiver core for the displaced block |
| rem_way_o | output | 3 | Way in that receiver's set |
| swap_o | output | 1 | Swap the remotely hit block with victim_o |

## Verification
The assertions assume three things about the inputs. First, every input stays constant from the accepted start until done. Second, at least one core is marked receiver whenever a miss starts. Third, the slot picked first in the receiver holds a block, so the spiller scan always finds a valid entry. The bench changes distances, roles and remote-set contents only while the block is idle, and every miss scenario keeps a receiver bit clear. The bench also makes the candidate slot of each spiller-path test a valid entry owned by that spiller.

// File: rtl/ps_pkg.sv
// Shared types for the placement selector.
// Assumes: one-bit operation code, five controller states.
package ps_pkg;
    typedef enum logic {
        OP_MISS = 1'b0,
        OP_RHIT = 1'b1
    } place_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN_L,
        S_SEL,
        S_SCAN_R,
        S_FIN
    } sel_state_e;
endpackage

// File: rtl/ps_lfsr.sv
// Free-running Galois LFSR giving pseudo-random low bits.
// Assumes: SEED nonzero, TAPS a maximal polynomial for W.
module ps_lfsr #(
    parameter int W = 8,
    parameter int OW = 2,
    parameter logic [W-1:0] SEED = 8'hA5,
    parameter logic [W-1:0] TAPS = 8'hB8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [OW-1:0] rnd_o
);
    logic [W-1:0] st_q;

    // step the register once per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SEED;
        else        st_q <= (st_q >> 1) ^ (st_q[0] ? TAPS : '0);
    end

    assign rnd_o = st_q[OW-1:0];

    // R5: random source never locks up in the all-zero state
    assert_lfsr_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != '0);
endmodule

// File: rtl/ps_rcv_pick.sv
// Picks a receiver core: the first core at or after a start offset,
// walking upward with wrap, whose role bit is 0.
// Assumes: NCORES is a power of two.
module ps_rcv_pick #(
    parameter int NCORES = 4,
    parameter int CW = 2
) (
    input  logic [NCORES-1:0] role_i,
    input  logic [CW-1:0]     base_i,
    output logic [CW-1:0]     pick_o,
    output logic              found_o
);
    // search downward so the nearest offset is written last
    always_comb begin
        pick_o  = '0;
        found_o = 1'b0;
        for (int k = NCORES - 1; k >= 0; k--) begin
            if (!role_i[(int'(base_i) + k) % NCORES]) begin
                pick_o  = CW'((int'(base_i) + k) % NCORES);
                found_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ps_far_scan.sv
// Sequential arg-max: takes one candidate per enabled cycle and keeps
// the largest distance. A strict compare keeps the earliest index on ties.
// Assumes: clr and en are never high together.
module ps_far_scan #(
    parameter int DW = 8,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          cand_ok,
    input  logic [DW-1:0] cand_dist,
    input  logic [IW-1:0] cand_idx,
    output logic          best_valid,
    output logic [IW-1:0] best_idx
);
    logic [DW-1:0] best_dist_q;

    // keep the farthest qualifying candidate seen since the last clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            best_valid  <= 1'b0;
            best_dist_q <= '0;
            best_idx    <= '0;
        end else if (en && cand_ok && (!best_valid || cand_dist > best_dist_q)) begin
            best_valid  <= 1'b1;
            best_dist_q <= cand_dist;
            best_idx    <= cand_idx;
        end
    end

    // R2: the held maximum never shrinks between clears
    assert_best_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (best_valid && !clr) |=> (best_valid && best_dist_q >= $past(best_dist_q)));
    // R3: a later equal candidate never displaces the held one
    assert_tie_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (best_valid && !clr && en && cand_ok && cand_dist == best_dist_q)
        |=> $stable(best_idx));
endmodule

// File: rtl/oracle_place_sel.sv
// Oracle placement selector for one set of a spiller core.
// Miss: scans WAYS local distances plus the incoming one, then picks a
// receiver slot in two steps (LRU slot, else the owning spiller's
// farthest block in receiver caches). Remote hit: scans the same
// candidates and requests a swap unless the hit block is farthest.
// Assumes: inputs stable from accepted start to done, WAYS and NCORES
// powers of two, at least one receiver on a miss.
module oracle_place_sel
    import ps_pkg::*;
#(
    parameter int WAYS   = 8,
    parameter int NCORES = 4,
    parameter int DW     = 8,
    parameter int LFSR_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          op_i,
    input  logic [WAYS*DW-1:0]            local_dist_i,
    input  logic [DW-1:0]                 cand_dist_i,
    input  logic [NCORES-1:0]             role_i,
    input  logic [NCORES*WAYS*DW-1:0]     rem_dist_i,
    input  logic [NCORES*WAYS*$clog2(NCORES)-1:0] rem_owner_i,
    input  logic [NCORES*WAYS-1:0]        rem_valid_i,
    input  logic [NCORES*$clog2(WAYS)-1:0] rem_lru_i,
    output logic                          done_o,
    output logic                          supply_o,
    output logic [$clog2(WAYS+1)-1:0]     victim_o,
    output logic                          bypass_o,
    output logic                          place_o,
    output logic [$clog2(NCORES)-1:0]     rem_core_o,
    output logic [$clog2(WAYS)-1:0]       rem_way_o,
    output logic                          swap_o
);
    localparam int WW   = $clog2(WAYS);
    localparam int CW   = $clog2(NCORES);
    localparam int NENT = NCORES * WAYS;
    localparam int EW   = $clog2(NENT);
    localparam int VW   = $clog2(WAYS + 1);
    localparam int PW   = $clog2(NENT + WAYS + 1);

    sel_state_e      state_q;
    place_op_e       op_q;
    logic [PW-1:0]   ptr_q;
    logic [CW-1:0]   spl_q;
    logic [VW-1:0]   victim_q;

    logic            scan_clr, scan_en, cand_ok;
    logic [DW-1:0]   cand_dist;
    logic            best_valid;
    logic [PW-1:0]   best_idx;

    logic [CW-1:0]   rnd;
    logic [CW-1:0]   pick_c;
    logic            pick_ok_c;
    logic [WW-1:0]   lru_c;
    logic [EW-1:0]   ent_c;
    logic [CW-1:0]   own_c;
    logic            vld_c;
    int              lidx, ridx;

    ps_lfsr #(.W(LFSR_W), .OW(CW)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_o (rnd)
    );

    ps_rcv_pick #(.NCORES(NCORES), .CW(CW)) u_pick (
        .role_i  (role_i),
        .base_i  (rnd),
        .pick_o  (pick_c),
        .found_o (pick_ok_c)
    );

    ps_far_scan #(.DW(DW), .IW(PW)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (scan_clr),
        .en         (scan_en),
        .cand_ok    (cand_ok),
        .cand_dist  (cand_dist),
        .cand_idx   (ptr_q),
        .best_valid (best_valid),
        .best_idx   (best_idx)
    );

    // look up the first-step slot of the chosen receiver
    always_comb begin
        lru_c = rem_lru_i[int'(pick_c)*WW +: WW];
        ent_c = {pick_c, lru_c};
        own_c = rem_owner_i[int'(ent_c)*CW +: CW];
        vld_c = rem_valid_i[ent_c];
    end

    // present the candidate addressed by the scan pointer
    always_comb begin
        lidx      = (int'(ptr_q) < WAYS) ? int'(ptr_q) : 0;
        ridx      = (int'(ptr_q) < NENT) ? int'(ptr_q) : 0;
        scan_clr  = (state_q == S_IDLE && start_i) || (state_q == S_SEL);
        scan_en   = (state_q == S_SCAN_L) || (state_q == S_SCAN_R);
        cand_ok   = 1'b1;
        cand_dist = (int'(ptr_q) < WAYS) ? local_dist_i[lidx*DW +: DW] : cand_dist_i;
        if (state_q == S_SCAN_R) begin
            cand_dist = rem_dist_i[ridx*DW +: DW];
            cand_ok   = rem_valid_i[ridx]
                      && !role_i[CW'(ridx / WAYS)]
                      && (rem_owner_i[ridx*CW +: CW] == spl_q);
        end
    end

    // controller: scan, decide, and publish results with a done strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            op_q       <= OP_MISS;
            ptr_q      <= '0;
            spl_q      <= '0;
            victim_q   <= '0;
            done_o     <= 1'b0;
            supply_o   <= 1'b0;
            victim_o   <= '0;
            bypass_o   <= 1'b0;
            place_o    <= 1'b0;
            rem_core_o <= '0;
            rem_way_o  <= '0;
            swap_o     <= 1'b0;
        end else begin
            done_o   <= 1'b0;
            supply_o <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        op_q    <= place_op_e'(op_i);
                        ptr_q   <= '0;
                        state_q <= S_SCAN_L;
                    end
                end
                S_SCAN_L: begin
                    if (ptr_q == PW'(WAYS)) state_q <= S_SEL;
                    else                    ptr_q   <= ptr_q + 1'b1;
                end
                S_SEL: begin
                    victim_q <= VW'(best_idx);
                    if (op_q == OP_RHIT) begin
                        victim_o   <= VW'(best_idx);
                        swap_o     <= (best_idx != PW'(WAYS));
                        bypass_o   <= 1'b0;
                        place_o    <= 1'b0;
                        rem_core_o <= '0;
                        rem_way_o  <= '0;
                        done_o     <= 1'b1;
                        supply_o   <= 1'b1;
                        state_q    <= S_IDLE;
                    end else if (!vld_c || !role_i[own_c]) begin
                        victim_o   <= VW'(best_idx);
                        bypass_o   <= (best_idx == PW'(WAYS));
                        place_o    <= 1'b1;
                        swap_o     <= 1'b0;
                        rem_core_o <= pick_c;
                        rem_way_o  <= lru_c;
                        done_o     <= 1'b1;
                        supply_o   <= 1'b1;
                        state_q    <= S_IDLE;
                    end else begin
                        spl_q   <= own_c;
                        ptr_q   <= '0;
                        state_q <= S_SCAN_R;
                    end
                end
                S_SCAN_R: begin
                    if (ptr_q == PW'(NENT - 1)) state_q <= S_FIN;
                    else                        ptr_q   <= ptr_q + 1'b1;
                end
                S_FIN: begin
                    victim_o   <= victim_q;
                    bypass_o   <= (victim_q == VW'(WAYS));
                    place_o    <= 1'b1;
                    swap_o     <= 1'b0;
                    rem_core_o <= CW'(best_idx >> WW);
                    rem_way_o  <= WW'(best_idx);
                    done_o     <= 1'b1;
                    supply_o   <= 1'b1;
                    state_q    <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R4: a bypass is always a remote placement of candidate WAYS
    assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && bypass_o) |-> (place_o && victim_o == VW'(WAYS)));
    // R5: a miss only starts with a receiver available
    assert_rcv_exists_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start_i && op_i == 1'b0) |-> (role_i != '1));
    // R5: the receiver pick succeeds when the decision is taken
    assert_pick_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SEL && op_q == OP_MISS) |-> pick_ok_c);
    // R5: the published slot lives in a receiver core
    assert_rcv_role_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && place_o) |-> !role_i[rem_core_o]);
    // R7: the spiller scan always finds at least its own LRU slot
    assert_spill_found_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FIN) |-> best_valid);
    // R8: a swap never names the hit block and never places remotely
    assert_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && swap_o) |-> (!place_o && victim_o != VW'(WAYS)));
    // R11: done is a single-cycle strobe
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R11: inputs are held while an operation is in flight
    assert_hold_inputs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && $past(state_q) != S_IDLE)
        |-> ($stable(role_i) && $stable(cand_dist_i) && $stable(local_dist_i)));
endmodule

// File: tb/oracle_place_sel_tb_top.sv
// Directed bench for the placement selector: one task per scenario.
module oracle_place_sel_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic        start_i = 1'b0;
    logic        op_i = 1'b0;
    logic [7:0]  ld [8];
    logic [7:0]  ind;
    logic [3:0]  role;
    logic [7:0]  rdist [32];
    logic [1:0]  rown [32];
    logic        rval [32];
    logic [2:0]  rlru [4];

    logic [63:0]  local_dist;
    logic [255:0] rem_dist;
    logic [63:0]  rem_owner;
    logic [31:0]  rem_valid;
    logic [11:0]  rem_lru;

    logic       done_o, supply_o, bypass_o, place_o, swap_o;
    logic [3:0] victim_o;
    logic [1:0] rem_core_o;
    logic [2:0] rem_way_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int lat;
    bit ended = 1'b0;

    always_comb begin
        for (int i = 0; i < 8; i++) local_dist[i*8 +: 8] = ld[i];
        for (int i = 0; i < 32; i++) begin
            rem_dist[i*8 +: 8]  = rdist[i];
            rem_owner[i*2 +: 2] = rown[i];
            rem_valid[i]        = rval[i];
        end
        for (int i = 0; i < 4; i++) rem_lru[i*3 +: 3] = rlru[i];
    end

    oracle_place_sel dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .op_i         (op_i),
        .local_dist_i (local_dist),
        .cand_dist_i  (ind),
        .role_i       (role),
        .rem_dist_i   (rem_dist),
        .rem_owner_i  (rem_owner),
        .rem_valid_i  (rem_valid),
        .rem_lru_i    (rem_lru),
        .done_o       (done_o),
        .supply_o     (supply_o),
        .victim_o     (victim_o),
        .bypass_o     (bypass_o),
        .place_o      (place_o),
        .rem_core_o   (rem_core_o),
        .rem_way_o    (rem_way_o),
        .swap_o       (swap_o)
    );

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // watchdog: a hung run is one failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // farthest candidate, lowest index on ties, incoming = 8
    function automatic int far_idx();
        int b = 0;
        logic [7:0] bd = ld[0];
        for (int i = 1; i < 9; i++) begin
            logic [7:0] d = (i < 8) ? ld[i] : ind;
            if (d > bd) begin
                bd = d;
                b = i;
            end
        end
        return b;
    endfunction

    task automatic base_fill();
        for (int i = 0; i < 8; i++) ld[i] = 8'(i * 5 + 1);
        ind = 8'd3;
        role = 4'b1101;
        for (int i = 0; i < 32; i++) begin
            rdist[i] = 8'(i * 7);
            rown[i]  = 2'(i / 8);
            rval[i]  = 1'b1;
        end
        for (int i = 0; i < 4; i++) rlru[i] = 3'd0;
    endtask

    // issue one operation and wait for done; lat counts edges from start
    task automatic run_op(logic op);
        @(negedge clk);
        op_i = op;
        start_i = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && lat < 400) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 done", int'(done_o), 0);
        chk("R1 supply", int'(supply_o), 0);
        chk("R1 victim", int'(victim_o), 0);
        chk("R1 flags", int'({bypass_o, place_o, swap_o}), 0);
        chk("R1 slot", int'({rem_core_o, rem_way_o}), 0);
    endtask

    task automatic t_miss_local();
        base_fill();
        ld[3] = 8'd200;
        rlru[1] = 3'd5;
        run_op(1'b0);
        chk("R2 victim local", int'(victim_o), far_idx());
        chk("R2 victim is way3", int'(victim_o), 3);
        chk("R4 no bypass", int'(bypass_o), 0);
        chk("R4 place", int'(place_o), 1);
        chk("R5 single receiver", int'(rem_core_o), 1);
        chk("R6 receiver-owned lru way", int'(rem_way_o), 5);
        chk("R9 supply with done", int'(supply_o), 1);
    endtask

    task automatic t_miss_bypass();
        base_fill();
        ind = 8'd250;
        run_op(1'b0);
        chk("R2 incoming farthest", int'(victim_o), 8);
        chk("R4 bypass", int'(bypass_o), 1);
        chk("R9 supply on bypass", int'(supply_o), 1);
    endtask

    task automatic t_ties();
        base_fill();
        for (int i = 0; i < 8; i++) ld[i] = 8'hFF;
        ind = 8'hFF;
        run_op(1'b0);
        chk("R3 all no-future pick way0", int'(victim_o), 0);
        chk("R3 no bypass on tie", int'(bypass_o), 0);
        base_fill();
        ld[2] = 8'd90;
        ld[6] = 8'd90;
        ind = 8'd90;
        run_op(1'b0);
        chk("R3 equal ways pick lower", int'(victim_o), 2);
        base_fill();
        ind = 8'hFF;
        ld[4] = 8'hFE;
        run_op(1'b0);
        chk("R3 no-future incoming farthest", int'(victim_o), 8);
    endtask

    task automatic t_spill_lru();
        base_fill();
        rlru[1] = 3'd2;
        rown[10] = 2'd0; rdist[10] = 8'd10;
        rown[12] = 2'd0; rdist[12] = 8'd50;
        rown[15] = 2'd0; rdist[15] = 8'd50;
        rown[9]  = 2'd0; rdist[9]  = 8'd255; rval[9] = 1'b0;
        rown[16] = 2'd0; rdist[16] = 8'd200;
        run_op(1'b0);
        chk("R7 spiller farthest core", int'(rem_core_o), 1);
        chk("R7 spiller farthest way tie-low", int'(rem_way_o), 4);
        chk("R7 place", int'(place_o), 1);
        base_fill();
        rlru[1] = 3'd2;
        rown[10] = 2'd3; rdist[10] = 8'd30;
        run_op(1'b0);
        chk("R7 other spiller only slot", int'(rem_way_o), 2);
    endtask

    task automatic t_invalid_lru();
        base_fill();
        rlru[1] = 3'd6;
        rval[14] = 1'b0;
        rown[14] = 2'd0;
        run_op(1'b0);
        chk("R6 empty lru slot core", int'(rem_core_o), 1);
        chk("R6 empty lru slot way", int'(rem_way_o), 6);
    endtask

    task automatic t_rhit();
        base_fill();
        ld[5] = 8'd180;
        ind = 8'd100;
        run_op(1'b1);
        chk("R8 swap local farthest", int'(swap_o), 1);
        chk("R8 victim way5", int'(victim_o), 5);
        chk("R4 hit no place", int'(place_o), 0);
        chk("R9 supply on hit", int'(supply_o), 1);
        chk("R10 hit latency", lat, 11);
        base_fill();
        ind = 8'd220;
        run_op(1'b1);
        chk("R8 hit block stays", int'(swap_o), 0);
        chk("R8 victim hit block", int'(victim_o), 8);
        chk("R4 hit no bypass", int'(bypass_o), 0);
        base_fill();
        ld[1] = 8'd220;
        ind = 8'd220;
        run_op(1'b1);
        chk("R8 tie favours local swap", int'(swap_o), 1);
    endtask

    task automatic t_multi_rcv();
        base_fill();
        role = 4'b0101;
        for (int n = 0; n < 6; n++) begin
            run_op(1'b0);
            chk("R5 picked core is receiver", int'(role[rem_core_o]), 0);
            chk("R6 lru way used", int'(rem_way_o), 0);
            repeat (n + 1) @(negedge clk);
        end
    endtask

    task automatic t_busy_start();
        int dones = 0;
        base_fill();
        ld[7] = 8'd240;
        @(negedge clk);
        op_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        op_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        op_i = 1'b0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (done_o) begin
                dones++;
                chk("R11 result of first op place", int'(place_o), 1);
                chk("R11 result of first op victim", int'(victim_o), 7);
            end
        end
        chk("R11 single done", dones, 1);
    endtask

    initial begin
        base_fill();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_miss_local();
        t_miss_bypass();
        t_ties();
        t_spill_lru();
        t_invalid_lru();
        t_rhit();
        t_multi_rcv();
        t_busy_start();
        repeat (4) @(negedge clk);
        summary();
    end
endmodule